// File: doc/BRIEF.md
# Block-Mode Configuration Register Slave

This block is a two-wire serial bus slave (SMBus / I2C style) that gives a host access to a small bank of 8-bit configuration registers. The block oversamples SCL and SDA with its own system clock. It pulls SDA low through an output-enable, and the chip-level pad resolves that enable as open drain. The whole register bank is presented as one flat parallel output, so neighbouring logic can use the settings directly.

The slave answers at 7-bit address 69h, which makes the write address byte D2h and the read address byte D3h. A block write carries a command byte, a count byte and then data bytes. The slave accepts the command and count bytes but does not use them, and it always stores the data starting at register 0. A block read returns a count byte first and then registers 0, 1, 2 and so on. The count comes from a writable count register.

One register reads back the inverted strap inputs, which are captured once after reset. A second register holds fixed identification constants. Both are read-only. SCL and SDA each pass through a synchronizer and a glitch filter before the slave looks for START and STOP conditions or clock edges.

Top module: `smb_cfg_slave`

## Requirements
- R1: After reset, every register reads 00h except three: register 6 (count) reads 06h, register 7 reads {3'b000, ~strap_i}, and register 11 reads {ID_REV, 4'b0001}. sda_oe_o is 0 after reset.
- R2: An address byte of D2h (write) or D3h (read) is acknowledged by driving SDA low in the ninth clock. Any other address is not acknowledged. The slave then leaves SDA released for the rest of that transaction, and it stores nothing until the next START.
- R3: In a write, the first two bytes after the address (command and count) are acknowledged and then discarded. Each following data byte is acknowledged and stored in register 0, 1, 2 and onward, in order.
- R4: Register 7 holds the bitwise inverse of strap_i, captured in the first clock after reset is released, with bits 7:5 set to zero. Register 11 holds {ID_REV, 4'b0001}. Writes to either register are acknowledged and discarded, and later changes on strap_i leave register 7 unchanged.
- R5: Data bytes that fall at index NREG or beyond are acknowledged and dropped.
- R6: A read returns the effective byte count first and then registers 0, 1, 2 and onward. Register indices at NREG or beyond read as 00h.
- R7: Register 6 sets the read length. After the slave has sent that many data bytes, it leaves SDA released, so the host reads FFh.
- R8: A value of 00h in register 6 is treated as 01h, both in the count byte that is returned and in the read length.
- R9: A repeated START in the middle of a byte drops the partial byte without storing it and starts address decoding again.
- R10: A pulse on SCL or SDA that lasts less than FILT system clocks has no effect. This holds for a false clock edge and for a false START.
- R11: The slave changes sda_oe_o only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used for oversampling |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock as sensed at the pad |
| sda_i | input | 1 | Bus data as sensed at the pad |
| strap_i | input | 5 | Strap pins, captured once after reset |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| regs_o | output | 8*NREG | Register bank, with register i in bits 8i+7:8i |

## Verification
The bench uses the default NREG of 12 and a FILT of 2, with a bus quarter-period of 16 system clocks. With NREG at 12, a 14-byte write reaches past the last register, so the dropped bytes at indices 12 and 13 can be checked. A FILT of 2 means a single-clock pulse on SCL, or a single-clock dip on SDA while SCL is high, is exactly the kind of glitch the filter must reject. The same write also lands on registers 6, 7 and 11, so one transaction sets the read length and exercises the protection of both read-only registers.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;
  localparam int unsigned IDXW      = 8;
  localparam int unsigned CNT_IDX   = 6;
  localparam int unsigned STRAP_IDX = 7;
  localparam int unsigned ID_IDX    = 11;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_RACK, ST_WBYTE, ST_TX, ST_HACK, ST_SKIP
  } smb_st_e;
endpackage

// File: rtl/smb_line_filter.sv
module smb_line_filter #(
  parameter int unsigned FILT = 2  // must be >= 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  logic [1:0]      sync_q;
  logic [FILT-1:0] hist_q;
  logic            q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      hist_q <= '1;
      q      <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      hist_q <= {hist_q[FILT-2:0], sync_q[1]};
      if (&hist_q)       q <= 1'b1;
      else if (~|hist_q) q <= 1'b0;
    end
  end

  assign line_o = q;

  // R10
  filt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(q) |-> ($past(hist_q[0]) == q));
endmodule

// File: rtl/smb_proto_fsm.sv
module smb_proto_fsm
  import smb_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            scl_f_i,
  input  logic            sda_f_i,
  input  logic [7:0]      cnt_i,
  input  logic [7:0]      rd_data_i,
  output logic [IDXW-1:0] rd_addr_o,
  output logic            wr_en_o,
  output logic [IDXW-1:0] wr_addr_o,
  output logic [7:0]      wr_data_o,
  output logic            sda_oe_o
);
  smb_st_e         st;
  logic [7:0]      sh;
  logic [3:0]      bitc;
  logic            rw, nack, oe_q, scl_d, sda_d;
  logic [IDXW-1:0] idx;
  logic [7:0]      eff_cnt, tx_byte;
  logic            scl_rise, scl_fall, start_c, stop_c;

  assign scl_rise = scl_f_i & ~scl_d;
  assign scl_fall = ~scl_f_i & scl_d;
  assign start_c  = scl_f_i & scl_d & sda_d & ~sda_f_i;
  assign stop_c   = scl_f_i & scl_d & ~sda_d & sda_f_i;

  assign eff_cnt   = (cnt_i == 8'h00) ? 8'h01 : cnt_i;
  assign rd_addr_o = idx - 1'b1;

  always_comb begin
    if (idx == '0)                       tx_byte = eff_cnt;
    else if (rd_addr_o >= IDXW'(eff_cnt)) tx_byte = 8'hFF;  // released bus
    else                                 tx_byte = rd_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= ST_IDLE; sh <= '0; bitc <= '0; rw <= 1'b0; nack <= 1'b0;
      oe_q <= 1'b0; scl_d <= 1'b1; sda_d <= 1'b1; idx <= '0;
      wr_en_o <= 1'b0; wr_addr_o <= '0; wr_data_o <= '0;
    end else begin
      scl_d   <= scl_f_i;
      sda_d   <= sda_f_i;
      wr_en_o <= 1'b0;
      if (start_c) begin
        st <= ST_ADDR; bitc <= '0; idx <= '0; oe_q <= 1'b0;
      end else if (stop_c) begin
        st <= ST_IDLE; oe_q <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR, ST_WBYTE: begin
            if (scl_rise) begin
              sh   <= {sh[6:0], sda_f_i};
              bitc <= bitc + 1'b1;
            end else if (scl_fall && bitc == 4'd8) begin
              bitc <= '0;
              if (st == ST_ADDR) begin
                if (sh[7:1] == DEV_ADDR) begin
                  rw <= sh[0]; oe_q <= 1'b1; st <= ST_RACK;
                end else begin
                  st <= ST_SKIP;
                end
              end else begin
                oe_q <= 1'b1;
                st   <= ST_RACK;
                if (idx >= IDXW'(2)) begin
                  wr_en_o   <= 1'b1;
                  wr_addr_o <= idx - IDXW'(2);
                  wr_data_o <= sh;
                end
                if (idx != '1) idx <= idx + 1'b1;
              end
            end
          end
          ST_RACK: if (scl_fall) begin
            if (rw) begin
              sh <= tx_byte; oe_q <= ~tx_byte[7]; bitc <= '0; st <= ST_TX;
              if (idx != '1) idx <= idx + 1'b1;
            end else begin
              oe_q <= 1'b0; st <= ST_WBYTE;
            end
          end
          ST_TX: if (scl_fall) begin
            if (bitc == 4'd7) begin
              oe_q <= 1'b0; st <= ST_HACK;
            end else begin
              sh <= {sh[6:0], 1'b0}; oe_q <= ~sh[6]; bitc <= bitc + 1'b1;
            end
          end
          ST_HACK: begin
            if (scl_rise) nack <= sda_f_i;
            else if (scl_fall) begin
              if (nack) st <= ST_SKIP;
              else begin
                sh <= tx_byte; oe_q <= ~tx_byte[7]; bitc <= '0; st <= ST_TX;
                if (idx != '1) idx <= idx + 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o = oe_q;

  // R11
  oe_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_f_i && $past(scl_f_i)) |-> $stable(oe_q));
  // R2
  skip_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_SKIP) |-> !oe_q);
  // R3
  wr_in_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> !rw);
  // R8
  cnt_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_TX && bitc == 4'd0 && $past(idx) == '0 && idx == IDXW'(1)) |-> (sh != 8'h00));
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
  import smb_cfg_pkg::*;
#(
  parameter int unsigned NREG   = 12,
  parameter logic [3:0]  ID_REV = 4'h2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [4:0]        strap_i,
  input  logic              wr_en_i,
  input  logic [IDXW-1:0]   wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [IDXW-1:0]   rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic [7:0]        cnt_o,
  output logic [8*NREG-1:0] regs_o
);
  localparam int unsigned AW = $clog2(NREG);

  logic [7:0] val [NREG];
  logic [4:0] strap_q;
  logic       latched_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strap_q   <= '0;
      latched_q <= 1'b0;
    end else if (!latched_q) begin
      strap_q   <= strap_i;
      latched_q <= 1'b1;
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == STRAP_IDX) begin : g_strap
      assign val[i] = {3'b000, ~strap_q};
    end else if (i == ID_IDX) begin : g_id
      assign val[i] = {ID_REV, 4'b0001};
    end else begin : g_rw
      logic [7:0] r_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                  r_q <= (i == CNT_IDX) ? 8'h06 : 8'h00;
        else if (wr_en_i && wr_addr_i == IDXW'(i))    r_q <= wr_data_i;
      end
      assign val[i] = r_q;
    end
    assign regs_o[8*i +: 8] = val[i];
  end

  assign rd_data_o = (rd_addr_i < IDXW'(NREG)) ? val[rd_addr_i[AW-1:0]] : 8'h00;
  assign cnt_o     = val[CNT_IDX];

  // R4
  strap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(latched_q) |-> $stable(val[STRAP_IDX]));
endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
  import smb_cfg_pkg::*;
#(
  parameter int unsigned NREG     = 12,
  parameter int unsigned FILT     = 2,
  parameter logic [6:0]  DEV_ADDR = 7'h69,
  parameter logic [3:0]  ID_REV   = 4'h2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [4:0]        strap_i,
  output logic              sda_oe_o,
  output logic [8*NREG-1:0] regs_o
);
  logic [1:0]      raw, filt;
  logic [7:0]      cnt, rd_data, wr_data;
  logic [IDXW-1:0] rd_addr, wr_addr;
  logic            wr_en;

  assign raw = {sda_i, scl_i};

  for (genvar l = 0; l < 2; l++) begin : g_filt
    smb_line_filter #(.FILT(FILT)) u_filt (
      .clk_i(clk_i), .rst_ni(rst_ni), .line_i(raw[l]), .line_o(filt[l]));
  end

  smb_proto_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_f_i(filt[0]), .sda_f_i(filt[1]),
    .cnt_i(cnt), .rd_data_i(rd_data), .rd_addr_o(rd_addr),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .sda_oe_o(sda_oe_o));

  smb_reg_bank #(.NREG(NREG), .ID_REV(ID_REV)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .strap_i(strap_i),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .cnt_o(cnt), .regs_o(regs_o));
endmodule

// File: tb/smb_cfg_slave_bench.sv
`timescale 1ns/1ps
module smb_cfg_slave_bench;
  localparam int NREG = 12;
  localparam int FILT = 2;
  localparam logic [3:0] ID_REV = 4'h2;
  localparam int Q = 16;
  localparam logic [7:0] VEC [4][6] = '{
    '{8'h01, 8'h02, 8'h04, 8'h08, 8'h10, 8'h20},
    '{8'hFF, 8'h00, 8'hAA, 8'h55, 8'h80, 8'h7F},
    '{8'h3C, 8'hC3, 8'h5A, 8'hA5, 8'h0F, 8'hF0},
    '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01}
  };

  logic clk = 1'b0, rst_n = 1'b0, scl_h = 1'b1, sda_h = 1'b1;
  logic [4:0] strap = 5'b10110;
  logic sda_oe;
  logic [8*NREG-1:0] regs;
  logic sda_bus;
  int total = 0, bad = 0, viol = 0;
  logic [7:0] exp_r [NREG];
  logic [7:0] dbuf [16];
  logic scl_p = 1'b1, oe_p = 1'b0;

  always #5 clk = ~clk;
  assign sda_bus = sda_h & ~sda_oe;

  smb_cfg_slave #(.NREG(NREG), .FILT(FILT), .ID_REV(ID_REV)) u_smb_cfg_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_h), .sda_i(sda_bus),
    .strap_i(strap), .sda_oe_o(sda_oe), .regs_o(regs));

  // R11 monitor: slave must not move SDA while SCL held high
  always @(negedge clk) begin
    if (rst_n && scl_h && scl_p && (sda_oe != oe_p)) viol++;
    scl_p <= scl_h; oe_p <= sda_oe;
  end

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic bit_out(input logic b, input logic glitch);
    sda_h = b; w(Q);
    if (glitch) begin scl_h = 1'b1; w(1); scl_h = 1'b0; w(2); end
    scl_h = 1'b1; w(Q);
    if (glitch && b) begin sda_h = 1'b0; w(1); sda_h = 1'b1; end
    w(Q); scl_h = 1'b0; w(Q);
  endtask

  task automatic bit_in(output logic b);
    sda_h = 1'b1; w(Q); scl_h = 1'b1; w(Q); b = sda_bus; w(Q); scl_h = 1'b0; w(Q);
  endtask

  task automatic wr_byte(input logic [7:0] d, input logic glitch, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) bit_out(d[i], glitch);
    bit_in(x); ack = ~x;
  endtask

  task automatic rd_byte(output logic [7:0] d, input logic last);
    for (int i = 7; i >= 0; i--) bit_in(d[i]);
    bit_out(last, 1'b0);
  endtask

  task automatic start_c();
    sda_h = 1'b1; w(Q); scl_h = 1'b1; w(Q); sda_h = 1'b0; w(Q); scl_h = 1'b0; w(Q);
  endtask

  task automatic stop_c();
    sda_h = 1'b0; w(Q); scl_h = 1'b1; w(Q); sda_h = 1'b1; w(2*Q);
  endtask

  task automatic blk_write(input int n, input logic glitch, input string tag);
    logic a;
    start_c();
    wr_byte(8'hD2, 1'b0, a); check({tag, " R2 addr ack"}, {7'd0, a}, 8'd1);
    wr_byte(8'hA5, 1'b0, a); check({tag, " R3 cmd ack"}, {7'd0, a}, 8'd1);
    wr_byte(8'h5A, 1'b0, a); check({tag, " R3 cnt ack"}, {7'd0, a}, 8'd1);
    for (int k = 0; k < n; k++) begin
      wr_byte(dbuf[k], glitch, a);
      check({tag, " R3 R5 data ack"}, {7'd0, a}, 8'd1);
      if (k < NREG && k != 7 && k != 11) exp_r[k] = dbuf[k];
    end
    stop_c();
  endtask

  task automatic check_regs(input string tag);
    for (int i = 0; i < NREG; i++) check(tag, regs[8*i +: 8], exp_r[i]);
  endtask

  task automatic blk_read(input int n, input string tag);
    logic a;
    logic [7:0] d, eff, e;
    eff = (exp_r[6] == 8'h00) ? 8'h01 : exp_r[6];
    start_c();
    wr_byte(8'hD3, 1'b0, a); check({tag, " R2 rd addr ack"}, {7'd0, a}, 8'd1);
    rd_byte(d, 1'b0); check({tag, " R6 R8 count byte"}, d, eff);
    for (int k = 0; k < n; k++) begin
      rd_byte(d, k == n - 1);
      if (k >= int'(eff)) e = 8'hFF;
      else if (k >= NREG) e = 8'h00;
      else e = exp_r[k];
      check({tag, " R6 R7 data"}, d, e);
    end
    stop_c();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] d;
    for (int i = 0; i < NREG; i++) exp_r[i] = 8'h00;
    exp_r[6] = 8'h06; exp_r[7] = {3'b000, ~strap}; exp_r[11] = {ID_REV, 4'b0001};
    w(4); rst_n = 1'b1; w(8);
    // R1 reset state
    check_regs("R1 reset");
    check("R1 oe idle", {7'd0, sda_oe}, 8'd0);

    // table walk: write six bytes, compare, read back
    for (int v = 0; v < 4; v++) begin
      for (int k = 0; k < 6; k++) dbuf[k] = VEC[v][k];
      blk_write(6, 1'b0, "vec");
      check_regs("R3 vec regs");
      blk_read(6, "vec");
    end

    // R2 foreign address: NACK, following byte ignored
    start_c();
    wr_byte(8'hA0, 1'b0, a); check("R2 foreign nack", {7'd0, a}, 8'd0);
    wr_byte(8'h99, 1'b0, a); check("R2 ignored byte", {7'd0, a}, 8'd0);
    stop_c();
    check_regs("R2 regs untouched");

    // R4 R5 long write hits RO regs and runs past end; count set to 3
    for (int k = 0; k < 14; k++) dbuf[k] = 8'h10 + 8'(k);
    dbuf[6] = 8'h03;
    blk_write(14, 1'b0, "long");
    check_regs("R4 R5 long regs");
    blk_read(5, "R7 len3");

    // R8 count of zero acts as one
    for (int k = 0; k < 7; k++) dbuf[k] = 8'hC0 + 8'(k);
    dbuf[6] = 8'h00;
    blk_write(7, 1'b0, "zero");
    blk_read(3, "R8 len0");

    // R10 glitches on SCL low phase and SDA high phase
    dbuf[0] = 8'h3C;
    blk_write(1, 1'b1, "glitch");
    check("R10 glitch reg0", regs[7:0], 8'h3C);

    // R9 repeated start mid byte
    start_c();
    wr_byte(8'hD2, 1'b0, a);
    wr_byte(8'hA5, 1'b0, a);
    wr_byte(8'h55, 1'b0, a);
    bit_out(1'b1, 1'b0); bit_out(1'b0, 1'b0); bit_out(1'b1, 1'b0); bit_out(1'b0, 1'b0);
    start_c();
    wr_byte(8'hD3, 1'b0, a); check("R9 restart addr ack", {7'd0, a}, 8'd1);
    rd_byte(d, 1'b0); check("R9 count byte", d, 8'h01);
    rd_byte(d, 1'b1); check("R9 reg0 read", d, exp_r[0]);
    stop_c();
    check_regs("R9 regs untouched");

    // R4 strap change after capture
    strap = 5'b01001; w(20);
    check("R4 strap hold", regs[8*7 +: 8], exp_r[7]);

    check("R11 sda steady while scl high", 8'(viol), 8'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule